// File: doc/BRIEF.md
# Stepped 64-bit Timebase Counter

This block keeps a free-running 64-bit time count for a chip's timer subsystem. It does not add one on each advance. It adds a programmable step, and there is one step for each of the two source clocks: the crystal and the PLL. An input selects which step applies, so the count can keep real time whichever source clock is driving it. The live count goes out on a wide port to the alarm comparators that sit next to the block.

Software reaches the block through a small 32-bit register bus with an address, a write enable, write data and combinational read data. To preset the count, software writes a high staging word and a low staging word, then writes a trigger bit that copies both halves into the counter in one cycle. To read the count, software writes a capture bit. This copies the live value into two read-only words and raises a valid flag once those words hold the new value. The two halves of the copy always come from the same cycle, so software never sees a carry tear between them.

Top module: `stepped_timebase`

## Requirements
- R1: After reset:
  - the count is 0
  - the configuration word, both staging words and both capture words read 0
  - the step word reads 0x0000_0450 (crystal step 80, PLL step 1)
  - the capture control word at 0x38 reads 0
  - the identification word at 0xFC reads 0x0180_7160
- R2: The count changes only on a clock edge at which configuration bit 0 is set or `tick_en` is high. On any other edge it holds its value.
- R3: On an advancing edge the count grows by the crystal step, which is step word bits [9:0], when `clk_sel` is 0. It grows by the PLL step, which is bits [19:10], when `clk_sel` is 1.
- R4: The count wraps modulo 2^64.
- R5: The staging words are read/write: the high half at 0x08 and the low half at 0x0C. They hold their value when they are not written.
- R6: A write to 0x04 with bit 31 set copies {high staging word, low staging word} into the count at that edge. A write to 0x04 with bit 31 clear has no effect on the count. Offset 0x04 always reads 0.
- R7: When a load and an advance fall on the same edge, the count takes the staged value exactly, with no step added.
- R8: A write to 0x38 with bit 31 set captures the count present in that write cycle. The capture's high half reads at 0x3C and its low half at 0x40. The capture then stays fixed while the count moves on.
- R9: Bit 30 of 0x38 is the capture-valid flag. It reads 0 in the cycle after a capture request and 1 from the following cycle on. Bit 31 of 0x38 always reads 0.
- R10: The configuration word at 0x00 keeps only bit 0 (force advance) and bit 31 (register clock enable). Its other bits read 0.
- R11: Reads of unmapped offsets return 0. Writes to the capture words 0x3C and 0x40 are ignored.
- R12: The identification word at 0xFC is read/write.
- R13: The step word at 0x10 keeps only bits [19:0]. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| clk_sel | input | 1 | Source select: 0 applies the crystal step, 1 applies the PLL step |
| tick_en | input | 1 | Advance request for the current edge |
| count_o | output | 64 | Live count for the comparators |

## Verification
A wrong count shows on `count_o` at the next clock edge after the bad stimulus, so every count check is made one edge after the cause. A wrong staging or step value stays hidden until a load or a run of advances, but it then produces an exact arithmetic mismatch. The step vectors are chosen so that a carry across the 32-bit halves, a full 64-bit wrap and a zero step each produce a distinct result. A broken capture path shows in the two capture words and in the valid flag within two edges of the request. The bench samples these exactly one edge and two edges after the request, and again after the count has moved on, to show that the capture does not follow the live count.

// File: rtl/stb_pkg.sv
package stb_pkg;
   // Byte offsets on the register bus
   localparam logic [7:0] OFS_CFG     = 8'h00;
   localparam logic [7:0] OFS_LOAD    = 8'h04;
   localparam logic [7:0] OFS_STAGE_H = 8'h08;
   localparam logic [7:0] OFS_STAGE_L = 8'h0C;
   localparam logic [7:0] OFS_STEP    = 8'h10;
   localparam logic [7:0] OFS_SNAPCTL = 8'h38;
   localparam logic [7:0] OFS_SNAP_H  = 8'h3C;
   localparam logic [7:0] OFS_SNAP_L  = 8'h40;
   localparam logic [7:0] OFS_IDENT   = 8'hFC;

   // Selects which per-source step is added on an advance
   typedef enum logic {SRC_XTAL = 1'b0, SRC_PLL = 1'b1} src_e;
endpackage

// File: rtl/stb_regs.sv
module stb_regs
   import stb_pkg::*;
#(
   parameter int             ADDR_W    = 8,
   parameter int             BUS_W     = 32,
   parameter int             CNT_W     = 64,
   parameter int             STEP_W    = 10,
   parameter logic [9:0]     XTAL_RST  = 10'd80,
   parameter logic [9:0]     PLL_RST   = 10'd1,
   parameter logic [31:0]    IDENT_RST = 32'h0180_7160
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [BUS_W-1:0]  wdata_i,
   output logic [BUS_W-1:0]  rdata_o,
   input  logic [CNT_W-1:0]  snap_val_i,
   input  logic              snap_valid_i,
   output logic              force_adv_o,
   output logic [STEP_W-1:0] step_xtal_o,
   output logic [STEP_W-1:0] step_pll_o,
   output logic [CNT_W-1:0]  load_val_o,
   output logic              load_pulse_o,
   output logic              snap_req_o
);
   localparam int NWORD     = CNT_W / BUS_W;
   localparam int TRIG_BIT  = BUS_W - 1;
   localparam int VALID_BIT = BUS_W - 2;
   localparam int STEP_BITS = 2 * STEP_W;
   localparam logic [ADDR_W-1:0] A_CFG     = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_LOAD    = ADDR_W'(OFS_LOAD);
   localparam logic [ADDR_W-1:0] A_STAGE_H = ADDR_W'(OFS_STAGE_H);
   localparam logic [ADDR_W-1:0] A_STAGE_L = ADDR_W'(OFS_STAGE_L);
   localparam logic [ADDR_W-1:0] A_STEP    = ADDR_W'(OFS_STEP);
   localparam logic [ADDR_W-1:0] A_SNAPCTL = ADDR_W'(OFS_SNAPCTL);
   localparam logic [ADDR_W-1:0] A_SNAP_H  = ADDR_W'(OFS_SNAP_H);
   localparam logic [ADDR_W-1:0] A_SNAP_L  = ADDR_W'(OFS_SNAP_L);
   localparam logic [ADDR_W-1:0] A_IDENT   = ADDR_W'(OFS_IDENT);

   // Parameter checks made at elaboration
   if (CNT_W != 2 * BUS_W) begin : g_bad_cnt_w
      $error("stb_regs: CNT_W must be twice BUS_W");
   end
   if (STEP_BITS > BUS_W) begin : g_bad_step_w
      $error("stb_regs: two steps must fit one bus word");
   end
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("stb_regs: ADDR_W too small for the map");
   end
   if (STEP_W > 10) begin : g_bad_step_rst
      $error("stb_regs: step reset values are 10 bits wide");
   end

   logic                 cfg_force_q, cfg_regclk_q;
   logic [STEP_W-1:0]    step_x_q, step_p_q;
   logic [BUS_W-1:0]     ident_q;
   logic [BUS_W-1:0]     stage_q [NWORD];

   // Configuration word: force advance (bit 0) and register clock enable (top bit)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_force_q  <= 1'b0;
         cfg_regclk_q <= 1'b0;
      end else if (we_i && addr_i == A_CFG) begin
         cfg_force_q  <= wdata_i[0];
         cfg_regclk_q <= wdata_i[TRIG_BIT];
      end
   end

   // Per-source steps
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_x_q <= STEP_W'(XTAL_RST);
         step_p_q <= STEP_W'(PLL_RST);
      end else if (we_i && addr_i == A_STEP) begin
         step_x_q <= wdata_i[STEP_W-1:0];
         step_p_q <= wdata_i[STEP_BITS-1:STEP_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ident_q <= IDENT_RST;
      else if (we_i && addr_i == A_IDENT)   ident_q <= wdata_i;
   end

   // Staging words: word 0 is the low half, word 1 the high half
   for (genvar w = 0; w < NWORD; w++) begin : g_stage
      localparam logic [ADDR_W-1:0] WADDR = (w == 0) ? A_STAGE_L : A_STAGE_H;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        stage_q[w] <= '0;
         else if (we_i && addr_i == WADDR)  stage_q[w] <= wdata_i;
      end
      assign load_val_o[w*BUS_W +: BUS_W] = stage_q[w];
   end

   // Write-one triggers, active for the write cycle only
   assign load_pulse_o = we_i && (addr_i == A_LOAD)    && wdata_i[TRIG_BIT];
   assign snap_req_o   = we_i && (addr_i == A_SNAPCTL) && wdata_i[TRIG_BIT];

   assign force_adv_o = cfg_force_q;
   assign step_xtal_o = step_x_q;
   assign step_pll_o  = step_p_q;

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_CFG: begin
            rdata_o[0]        = cfg_force_q;
            rdata_o[TRIG_BIT] = cfg_regclk_q;
         end
         A_STAGE_H: rdata_o = stage_q[1];
         A_STAGE_L: rdata_o = stage_q[0];
         A_STEP:    rdata_o[STEP_BITS-1:0] = {step_p_q, step_x_q};
         A_SNAPCTL: rdata_o[VALID_BIT] = snap_valid_i;
         A_SNAP_H:  rdata_o = snap_val_i[CNT_W-1:BUS_W];
         A_SNAP_L:  rdata_o = snap_val_i[BUS_W-1:0];
         A_IDENT:   rdata_o = ident_q;
         default:   rdata_o = '0;
      endcase
   end

   AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(load_val_o)); // R5
endmodule

// File: rtl/stb_accum.sv
module stb_accum #(
   parameter int CNT_W  = 64,
   parameter int STEP_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CNT_W-1:0]  load_val_i,
   input  logic              adv_i,
   input  logic [STEP_W-1:0] step_i,
   output logic [CNT_W-1:0]  count_o
);
   localparam int PAD_W = CNT_W - STEP_W;

   if (STEP_W >= CNT_W) begin : g_bad_w
      $error("stb_accum: step must be narrower than the count");
   end

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] step_ext;

   assign step_ext = {{PAD_W{1'b0}}, step_i};

   // A load takes priority over an advance; the sum wraps at the count width
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count_q <= '0;
      else if (load_i) count_q <= load_val_i;
      else if (adv_i)  count_q <= count_q + step_ext;
   end

   assign count_o = count_q;

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> count_q == $past(load_val_i)); // R7
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_i) |=> $stable(count_q)); // R2
   AST_STEP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adv_i) |=> count_q == $past(count_q) + $past(step_ext)); // R3
endmodule

// File: rtl/stb_snap.sv
module stb_snap #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [CNT_W-1:0] snap_o,
   output logic             valid_o
);
   logic [CNT_W-1:0] snap_q;
   logic             pend_q, valid_q;

   // Capture at the request edge; the flag reports valid one edge later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q  <= '0;
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         pend_q <= req_i;
         if (req_i) begin
            snap_q  <= count_i;
            valid_q <= 1'b0;
         end else if (pend_q) begin
            valid_q <= 1'b1;
         end
      end
   end

   assign snap_o  = snap_q;
   assign valid_o = valid_q;

   AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> snap_q == $past(count_i)); // R8
   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> $stable(snap_q)); // R8
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> !valid_q); // R9
   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q) |-> $past(req_i, 2)); // R9
endmodule

// File: rtl/stepped_timebase.sv
module stepped_timebase
   import stb_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BUS_W  = 32,
   parameter int CNT_W  = 64,
   parameter int STEP_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              clk_sel,
   input  logic              tick_en,
   output logic [CNT_W-1:0]  count_o
);
   logic              force_adv, load_pulse, snap_req, snap_valid, adv;
   logic [STEP_W-1:0] step_x, step_p, step_cur;
   logic [CNT_W-1:0]  load_val, count, snap_val;
   src_e              src;

   stb_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CNT_W(CNT_W), .STEP_W(STEP_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr_i       (bus_addr),
      .we_i         (bus_we),
      .wdata_i      (bus_wdata),
      .rdata_o      (bus_rdata),
      .snap_val_i   (snap_val),
      .snap_valid_i (snap_valid),
      .force_adv_o  (force_adv),
      .step_xtal_o  (step_x),
      .step_pll_o   (step_p),
      .load_val_o   (load_val),
      .load_pulse_o (load_pulse),
      .snap_req_o   (snap_req)
   );

   assign src      = src_e'(clk_sel);
   assign step_cur = (src == SRC_PLL) ? step_p : step_x;
   assign adv      = force_adv | tick_en;

   stb_accum #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_pulse),
      .load_val_i (load_val),
      .adv_i      (adv),
      .step_i     (step_cur),
      .count_o    (count)
   );

   stb_snap #(.CNT_W(CNT_W)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (snap_req),
      .count_i (count),
      .snap_o  (snap_val),
      .valid_o (snap_valid)
   );

   assign count_o = count;
endmodule

// File: tb/stepped_timebase_bench.sv
module stepped_timebase_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        clk_sel = 1'b0;
   logic        tick_en = 1'b0;
   logic [63:0] count_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   stepped_timebase u_stepped_timebase (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_sel(clk_sel),
      .tick_en(tick_en), .count_o(count_o)
   );

   typedef struct packed {
      logic        sel;
      logic [9:0]  step;
      logic [63:0] start;
      logic [7:0]  n;
      logic [63:0] exp;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{1'b0, 10'd80,   64'h0,                  8'd10,  64'h320},
      '{1'b1, 10'd1,    64'h0000_0000_FFFF_FFFE, 8'd5,   64'h0000_0001_0000_0003},
      '{1'b0, 10'd1023, 64'h1234_5678_9ABC_DEF0, 8'd4,   64'h1234_5678_9ABC_EEEC},
      '{1'b1, 10'd7,    64'hFFFF_FFFF_FFFF_FFF0, 8'd3,   64'h5},
      '{1'b0, 10'd0,    64'hDEAD_BEEF_0000_0001, 8'd9,   64'hDEAD_BEEF_0000_0001},
      '{1'b1, 10'd512,  64'h0,                  8'd200, 64'h19000}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic load64(input logic [63:0] v);
      wr(8'h08, v[63:32]);
      wr(8'h0C, v[31:0]);
      wr(8'h04, 32'h8000_0000);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [63:0] c1, c2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 count", count_o, 64'h0);
      rd(8'h00, r); chk("R1 cfg", r, 0);
      rd(8'h10, r); chk("R1 step", r, 32'h0000_0450);
      rd(8'h38, r); chk("R1 snapctl", r, 0);
      rd(8'h3C, r); chk("R1 snap hi", r, 0);
      rd(8'h08, r); chk("R1 stage hi", r, 0);
      rd(8'hFC, r); chk("R1 ident", r, 32'h0180_7160);

      // Vector table: R3 step select, R4 wrap, R6 load
      foreach (VEC[i]) begin
         clk_sel = VEC[i].sel;
         if (VEC[i].sel) wr(8'h10, {12'h0, VEC[i].step, 10'd3});
         else            wr(8'h10, {12'h0, 10'd7, VEC[i].step});
         load64(VEC[i].start);
         chk("R6 load", count_o, VEC[i].start);
         tick_en = 1'b1;
         repeat (int'(VEC[i].n)) @(posedge clk);
         @(negedge clk);
         tick_en = 1'b0;
         chk((i == 3) ? "R4 wrap" : "R3 step", count_o, VEC[i].exp);
      end

      // R5 staging readback
      wr(8'h08, 32'hCAFE_0001); wr(8'h0C, 32'h0BAD_F00D);
      rd(8'h08, r); chk("R5 stage hi", r, 32'hCAFE_0001);
      rd(8'h0C, r); chk("R5 stage lo", r, 32'h0BAD_F00D);

      // R13 step word width
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, r); chk("R13 step mask", r, 32'h000F_FFFF);
      wr(8'h10, {12'h0, 10'd1, 10'd80});
      clk_sel = 1'b0;

      // R6 trigger bit clear: no load
      load64(64'd100);
      wr(8'h04, 32'h7FFF_FFFF);
      chk("R6 no-trigger", count_o, 64'd100);
      rd(8'h04, r); chk("R6 read zero", r, 0);

      // R2 no advance when idle
      repeat (5) @(negedge clk);
      chk("R2 idle hold", count_o, 64'd100);

      // R2 force advance through cfg bit 0, R10 masking
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, r); chk("R10 cfg mask", r, 32'h8000_0001);
      c1 = count_o;
      repeat (4) @(negedge clk);
      chk("R2 forced advance", count_o, c1 + 64'd320);
      wr(8'h00, 32'h0);
      c1 = count_o;
      repeat (4) @(negedge clk);
      chk("R2 advance stops", count_o, c1);

      // R7 load wins over simultaneous tick
      wr(8'h08, 32'h0000_0005); wr(8'h0C, 32'h0000_1000);
      tick_en = 1'b1;
      wr(8'h04, 32'h8000_0000);
      chk("R7 load priority", count_o, 64'h0000_0005_0000_1000);
      @(negedge clk);
      chk("R7 then step", count_o, 64'h0000_0005_0000_1050);

      // R8 capture while counting, R9 valid timing
      @(negedge clk);
      bus_addr = 8'h38; bus_we = 1'b1; bus_wdata = 32'h8000_0000;
      c2 = count_o;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
      rd(8'h38, r); chk("R9 valid low", r, 0);
      @(negedge clk);
      rd(8'h38, r); chk("R9 valid high", r, 32'h4000_0000);
      repeat (3) @(negedge clk);
      tick_en = 1'b0;
      rd(8'h3C, r); chk("R8 snap hi", r, c2[63:32]);
      rd(8'h40, r); chk("R8 snap lo", r, c2[31:0]);
      chk("R8 count moved", count_o, c2 + 64'd400);

      // R11 capture words read-only, unmapped reads
      wr(8'h40, 32'h1234_5678);
      rd(8'h40, r); chk("R11 snap ro", r, c2[31:0]);
      rd(8'h20, r); chk("R11 unmapped 0x20", r, 0);
      rd(8'h80, r); chk("R11 unmapped 0x80", r, 0);

      // R12 identification word writable
      wr(8'hFC, 32'h1357_9BDF);
      rd(8'hFC, r); chk("R12 ident rw", r, 32'h1357_9BDF);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule